// File: doc/BRIEF.md
# Shared-Bus Byte Copy Master

This block is the only master on a simple shared system bus made of a 16-bit address, separate read and write strobes and an 8-bit bidirectional data bus. The most significant address bit picks the target: 0 selects the memory region and 1 selects the output-port region. The lower 15 bits are the offset inside the region. Slaves run on the inverted master clock, so whatever the master sets up after a rising edge is sampled half a cycle later.

A start pulse makes the master copy a run of bytes out of memory into the output port. Each byte takes two bus cycles. In the first, the master reads from memory at the source offset plus the byte index, with the data bus released. In the second, it writes the byte it captured to the port at a fixed destination offset and drives the data bus itself. The length, the source offset and the destination offset are latched when the start is accepted. Busy and a one-cycle done pulse tell the requester when the copy is finished.

Top module: `bytecopy_master`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, both strobes, busy and done are low.
- R2: A start seen at a rising edge while idle puts the master into the read phase of byte 0 in the next cycle. In that cycle read is 1, write is 0 and the address is {1'b0, src}.
- R3: The read phase of byte k addresses {1'b0, (src + k) mod 2^15}. The offset wraps inside the memory region, and bit 15 stays 0.
- R4: Every read phase is followed by a write phase with write 1, read 0 and address {1'b1, dst}. During that phase the master drives the byte that was on the data bus at the end of the read phase.
- R5: Read and write are never high in the same cycle. The master drives the data bus only while write is high.
- R6: For a length N of 1 or more, busy is high for the 2N cycles that follow the start edge. Done is high only in the cycle after those, and busy is then low.
- R7: The length, source and destination are latched at start. A start pulse or a change to these inputs while busy has no effect on the copy in progress.
- R8: A length of 0 causes no bus cycle. Done pulses in the first cycle after the start edge, and busy stays low.
- R9: An asynchronous reset in the middle of a copy drops both strobes and busy at once. The next copy starts again at byte index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; slaves use its inverse |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Copy request, sampled only while idle |
| len_i | input | 8 | Number of bytes to copy (0 to 255) |
| src_off_i | input | 15 | First memory offset to read |
| dst_off_i | input | 15 | Port offset written for every byte |
| busy_o | output | 1 | High during the read and write phases |
| done_o | output | 1 | One-cycle pulse after the last write phase |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_addr_o | output | 16 | Bus address: region bit and offset |
| bus_data_io | inout | 8 | Shared data bus, driven only during writes |

## Verification
The start edge counts as cycle 0. The read of byte k is then due in cycle 2k and its write in cycle 2k+1. Done is due in cycle 2N, or in cycle 0 when the length is 0. The bench drives inputs and samples outputs on the falling edge, so each check lands inside the cycle in which the result must be present. The port model captures data on the falling edge, just as a slave on the inverted clock would. After the done cycle, the bench compares the captured bytes and offsets with a memory function it computes itself.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } bcm_state_e;
endpackage

// File: rtl/bcm_seq.sv
module bcm_seq
  import bcm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output bcm_state_e       state_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             load_o
);
  bcm_state_e       state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] len_q;
  logic             last_byte;

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign last_byte = (idx_q == CNT_W'(len_q - 1'b1));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: begin
        idx_d = '0;
        if (start_i) state_d = (len_i == '0) ? ST_FIN : ST_RD;
      end
      ST_RD:   state_d = ST_WR;
      ST_WR: begin
        idx_d   = idx_q + 1'b1;
        state_d = last_byte ? ST_FIN : ST_RD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (load_o) len_q <= len_i;
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

  // R4: a read phase is always followed by a write phase
  a_r4_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD) |=> (state_q == ST_WR));
  // R6: the finish state lasts exactly one cycle
  a_r6_fin_once: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |=> (state_q == ST_IDLE));
  // R7: the latched length cannot change while a copy runs
  a_r7_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(len_q));
endmodule

// File: rtl/bcm_addr.sv
module bcm_addr
  import bcm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-2:0] src_i,
  input  logic [ADDR_W-2:0] dst_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  bcm_state_e        state_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o
);
  localparam int OFF_W = ADDR_W - 1;

  logic [OFF_W-1:0] src_q, dst_q, rd_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (load_i) begin
      src_q <= src_i;
      dst_q <= dst_i;
    end
  end

  assign rd_off = OFF_W'(src_q + OFF_W'(idx_i));
  assign rd_o   = (state_i == ST_RD);
  assign wr_o   = (state_i == ST_WR);

  always_comb begin
    case (state_i)
      ST_RD:   addr_o = {1'b0, rd_off};
      ST_WR:   addr_o = {1'b1, dst_q};
      default: addr_o = '0;
    endcase
  end

  // R3: consecutive read phases step the offset by one, wrapping in the region
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o && $past(rd_o, 2)) |->
      (addr_o[OFF_W-1:0] == OFF_W'($past(addr_o[OFF_W-1:0], 2) + 1'b1)));
  // R7: the destination stays put while a copy runs
  a_r7_dst_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != ST_IDLE) |=> $stable(dst_q));
endmodule

// File: rtl/bcm_hold.sv
module bcm_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] hold_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_o <= '0;
    else if (cap_en_i) hold_o <= bus_i;
  end
endmodule

// File: rtl/bytecopy_master.sv
module bytecopy_master
  import bcm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [ADDR_W-2:0] src_off_i,
  input  logic [ADDR_W-2:0] dst_off_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  inout  wire  [DATA_W-1:0] bus_data_io
);
  bcm_state_e       state;
  logic [CNT_W-1:0] idx;
  logic             load;
  logic [DATA_W-1:0] hold;

  bcm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .state_o(state), .idx_o(idx), .load_o(load)
  );

  bcm_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(load), .src_i(src_off_i),
    .dst_i(dst_off_i), .idx_i(idx), .state_i(state),
    .addr_o(bus_addr_o), .rd_o(bus_rd_o), .wr_o(bus_wr_o)
  );

  bcm_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_en_i(bus_rd_o),
    .bus_i(bus_data_io), .hold_o(hold)
  );

  assign bus_data_io = bus_wr_o ? hold : {DATA_W{1'bz}};
  assign busy_o      = (state == ST_RD) || (state == ST_WR);
  assign done_o      = (state == ST_FIN);

  // R5: strobes are mutually exclusive
  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));
  // R4: the byte driven in a write phase is the one read in the phase before
  a_r4_echo: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |-> (bus_data_io == $past(bus_data_io)));
  // R6: done is a single-cycle pulse, never overlapping busy
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/tb_bytecopy_master.sv
`timescale 1ns / 1ps
module tb_bytecopy_master;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  len_i;
  logic [14:0] src_off_i, dst_off_i;
  logic        busy_o, done_o, bus_rd_o, bus_wr_o;
  logic [15:0] bus_addr_o;
  wire  [7:0]  bus_data_io;

  int n_chk = 0;
  int n_bad = 0;

  bytecopy_master dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .src_off_i(src_off_i), .dst_off_i(dst_off_i), .busy_o(busy_o),
    .done_o(done_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
    .bus_addr_o(bus_addr_o), .bus_data_io(bus_data_io)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [14:0] o);
    return o[7:0] ^ {o[14:8], 1'b0} ^ 8'h5A;
  endfunction

  // memory model: combinational read in the low region
  assign bus_data_io = (bus_rd_o && !bus_addr_o[15]) ? mem_byte(bus_addr_o[14:0]) : 8'bz;

  // port model on the inverted clock
  logic [7:0]  cap_data [0:2047];
  logic [14:0] cap_off  [0:2047];
  int cap_cnt = 0;
  always @(negedge clk) begin
    if (bus_wr_o && bus_addr_o[15]) begin
      cap_data[cap_cnt % 2048] <= bus_data_io;
      cap_off[cap_cnt % 2048]  <= bus_addr_o[14:0];
      cap_cnt <= cap_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_copy(input int n, input int src, input int dst, input bit disturb);
    int base;
    base = cap_cnt;
    @(negedge clk);
    len_i = 8'(n); src_off_i = 15'(src); dst_off_i = 15'(dst); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (n == 0) begin
      chk(done_o && !busy_o && !bus_rd_o && !bus_wr_o, "R8", int'(done_o), 1);
      @(negedge clk);
      chk(!done_o && !busy_o, "R8", int'(done_o), 0);
      chk(cap_cnt == base, "R8", cap_cnt - base, 0);
      return;
    end
    chk(bus_rd_o && !bus_wr_o && busy_o, "R2", int'(bus_rd_o), 1);
    chk(bus_addr_o == {1'b0, 15'(src)}, "R2", int'(bus_addr_o), src);
    for (int j = 1; j < 2 * n; j++) begin
      if (disturb && j == 1) begin
        start_i = 1'b1; len_i = 8'(n + 3); src_off_i = 15'(src + 7); dst_off_i = 15'(dst + 9);
      end
      if (disturb && j == 2) start_i = 1'b0;
      @(negedge clk);
      if (j % 2 == 0) begin
        chk(bus_rd_o && !bus_wr_o, "R5", int'(bus_wr_o), 0);
        chk(bus_addr_o == {1'b0, 15'(src + j / 2)}, "R3", int'(bus_addr_o),
            int'({1'b0, 15'(src + j / 2)}));
      end else begin
        chk(bus_wr_o && !bus_rd_o, "R4", int'(bus_wr_o), 1);
        chk(bus_addr_o == {1'b1, 15'(dst)}, "R4", int'(bus_addr_o), int'({1'b1, 15'(dst)}));
      end
      chk(busy_o && !done_o, "R6", int'(busy_o), 1);
    end
    start_i = 1'b0;
    @(negedge clk);
    chk(done_o && !busy_o && !bus_rd_o && !bus_wr_o, "R6", int'(done_o), 1);
    @(negedge clk);
    chk(!done_o, "R6", int'(done_o), 0);
    chk(cap_cnt - base == n, disturb ? "R7" : "R6", cap_cnt - base, n);
    for (int k = 0; k < n; k++) begin
      chk(cap_data[(base + k) % 2048] == mem_byte(15'(src + k)), disturb ? "R7" : "R4",
          int'(cap_data[(base + k) % 2048]), int'(mem_byte(15'(src + k))));
      chk(cap_off[(base + k) % 2048] == 15'(dst), "R4",
          int'(cap_off[(base + k) % 2048]), dst);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lens [6] = '{1, 2, 3, 5, 8, 255};
    int srcs [3] = '{0, 1234, 32765};
    rst_n = 1'b0; start_i = 1'b0; len_i = '0; src_off_i = '0; dst_off_i = '0;
    repeat (3) @(negedge clk);
    chk(!bus_rd_o && !bus_wr_o && !busy_o && !done_o, "R1", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_rd_o && !bus_wr_o && !busy_o && !done_o, "R1", int'(bus_rd_o), 0);

    foreach (lens[i])
      foreach (srcs[s])
        run_copy(lens[i], srcs[s], (i * 4099 + s * 77) % 32768, 1'b0);

    run_copy(0, 10, 20, 1'b0);     // R8
    run_copy(5, 300, 4000, 1'b1);  // R7
    run_copy(4, 32767, 32767, 1'b0); // R3 wrap at top of region

    // R9: reset in the middle of a copy
    @(negedge clk);
    len_i = 8'd6; src_off_i = 15'd40; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!bus_rd_o && !bus_wr_o && !busy_o, "R9", int'(busy_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_copy(3, 500, 12, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule